// File: doc/BRIEF.md
# Bit-Serial Scaling Accumulator Multiplier

This block forms the full product of a parallel W-bit multiplicand and a W-bit multiplier that is fed in one bit per clock, least significant bit first. A single registered adder does all the work. Its result is fed back into its own input shifted right by one place, so the running sum is halved on every step. When the incoming multiplier bit is 1, the multiplicand is added to the halved sum. When the bit is 0, the sum is only shifted. The bit that falls off the low end of the sum on each step is collected into a shift register, which becomes the low half of the product.

A one-cycle start pulse captures the multiplicand and the signedness mode and clears the sum. Over the next W cycles the multiplier bits are consumed. A one-cycle done pulse then marks the product as valid, and the product stays unchanged until the next start. In two's-complement mode the sum is sign-extended as it shifts, and the multiplicand is subtracted instead of added on the multiplier's sign bit.

The controller has three states:
- IDLE: waiting for a start pulse.
- RUN: consuming multiplier bits, with a bit counter.
- DONE: the single cycle in which done is high.

The transitions are:
- IDLE→RUN on start.
- RUN→RUN on start, which restarts the count.
- RUN→DONE after the W-th bit.
- DONE→RUN on start.
- DONE→IDLE otherwise.

Top module: `ser_scale_mul`

## Requirements
- R1: After reset, `done_o` is 0 and `product_o` is 0.
- R2: If `start_i` is high at a rising edge, then after that edge `product_o` reads 0 and `done_o` is 0. `mcand_i` and `signed_i` are captured at that edge.
- R3: Multiplier bit k (k = 0 is the LSB) is sampled from `mbit_i` at the (k+1)-th rising edge after the start edge. `done_o` is 0 during these W cycles. `done_o` is 1 in the cycle that follows the W-th of these edges, provided no new start has arrived.
- R4: When `signed_i` = 0 was captured, `product_o` at done equals the unsigned product of the two operands, 2W bits wide.
- R5: When `signed_i` = 1 was captured, `product_o` at done equals the two's-complement product, 2W bits wide. This covers the most negative operands.
- R6: After done, and until the next start, `product_o` holds its value whatever `mbit_i` does.
- R7: A start pulse during an operation abandons the partial product. The new operation completes with a single done, after W bits counted from the new start.
- R8: Changes on `mcand_i` and `signed_i` after the start edge have no effect on the product.
- R9: `done_o` is high for exactly one cycle per completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new product; captures operands and clears the sum |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned; sampled at start |
| mcand_i | input | W | Parallel multiplicand, sampled at start |
| mbit_i | input | 1 | Serial multiplier bit, LSB first, one per cycle after start |
| product_o | output | 2W | Product; valid from done until the next start |
| done_o | output | 1 | One-cycle pulse marking a valid product |

## Verification
The checker watches four things on every cycle:
- `done_o` never lasts more than one cycle.
- A start always leaves a zeroed product and no done in the following cycle.
- Done never directly follows a start.
- After done, the product stays frozen until a start arrives.

Some behaviours only the bench's scenarios can show. These are the arithmetic values in both modes, including the most negative operands. They also include the exact W-cycle latency, the abandonment of a product by a mid-run start, and the insensitivity to operand changes after start.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ssm_state_t;
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic step_o,
    output logic last_o,
    output logic done_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

    ssm_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (start_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = ST_DONE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        step_o = (state_q == ST_RUN) && !start_i;
        last_o = step_o && (cnt_q == LAST_CNT);
        done_o = (state_q == ST_DONE);
    end
endmodule

// File: rtl/ssm_acc.sv
module ssm_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         last_i,
    input  logic         bit_i,
    input  logic         sgn_i,
    input  logic [W-1:0] mcand_i,
    output logic [W-1:0] acc_o,
    output logic         shout_o
);
    localparam int AW = W + 1;
    localparam int SW = W + 2;

    logic [W-1:0]  mc_q;
    logic          sgn_q;
    logic [AW-1:0] acc_q;
    logic [SW-1:0] acc_x, add_x, sum;

    always_comb begin
        acc_x = {sgn_q & acc_q[AW-1], acc_q};
        add_x = bit_i ? {{2{sgn_q & mc_q[W-1]}}, mc_q} : '0;
        sum   = (last_i && sgn_q) ? (acc_x - add_x) : (acc_x + add_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_q  <= '0;
            sgn_q <= 1'b0;
            acc_q <= '0;
        end else if (clear_i) begin
            mc_q  <= mcand_i;
            sgn_q <= sgn_i;
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= sum[SW-1:1];
        end
    end

    assign acc_o   = acc_q[W-1:0];
    assign shout_o = sum[0];
endmodule

// File: rtl/ssm_lowsr.sv
module ssm_lowsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         in_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_o <= '0;
        else if (clear_i) q_o <= '0;
        else if (step_i)  q_o <= {in_i, q_o[W-1:1]};
    end
endmodule

// File: rtl/ser_scale_mul.sv
module ser_scale_mul #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   mcand_i,
    input  logic           mbit_i,
    output logic [2*W-1:0] product_o,
    output logic           done_o
);
    logic step, last, shout;
    logic [W-1:0] acc_hi, low_q;

    ssm_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .step_o(step), .last_o(last), .done_o(done_o)
    );

    ssm_acc #(.W(W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .step_i(step),
        .last_i(last), .bit_i(mbit_i), .sgn_i(signed_i), .mcand_i(mcand_i),
        .acc_o(acc_hi), .shout_o(shout)
    );

    ssm_lowsr #(.W(W)) u_low (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .step_i(step),
        .in_i(shout), .q_o(low_q)
    );

    assign product_o = {acc_hi, low_q};
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [2*W-1:0] product_o,
    input logic           done_o
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (product_o == '0) && !done_o);

    p_done_not_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(product_o));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !start_i && $past(done_o)) |=> $stable(product_o) || $past(start_i));
endmodule

bind ser_scale_mul ssm_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .product_o(product_o), .done_o(done_o)
);

// File: tb/tb_ser_scale_mul.sv
module tb_ser_scale_mul;
    localparam int  W      = 8;
    localparam time PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, signed_i = 1'b0, mbit_i = 1'b0;
    logic [W-1:0]   mcand_i = '0;
    logic [2*W-1:0] product_o;
    logic done_o;

    int total = 0, bad = 0;
    logic [2*W-1:0] exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    ser_scale_mul #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .mcand_i(mcand_i), .mbit_i(mbit_i), .product_o(product_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input bit s);
        logic [2*W-1:0] ea, eb;
        ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    // monitor: pops expected products on done (R4, R5, R7)
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", product_o, '0);
            end else begin
                logic [2*W-1:0] e;
                e = exp_q.pop_front();
                check(product_o == e, "R4/R5 product", product_o, e);
            end
        end
    end

    // driver; abort_after >= 0 feeds that many bits then leaves (R7)
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                           input int abort_after);
        @(negedge clk);
        start_i = 1'b1; mcand_i = a; signed_i = s;
        if (abort_after < 0) exp_q.push_back(model(a, b, s));
        for (int k = 0; k < W; k++) begin
            if (abort_after >= 0 && k == abort_after) return;
            @(negedge clk);
            start_i = 1'b0;
            mbit_i = b[k];
            if (k == 0) check(product_o == '0, "R2 cleared at start", product_o, '0);
            if (k == 1) begin mcand_i = ~a; signed_i = ~s; end // R8
            check(done_o == 1'b0, "R3 no early done", {2*W-1'b0, done_o}, '0);
        end
        @(negedge clk);
        check(done_o == 1'b1, "R3 done after W bits", {2*W-1'b0, done_o}, 1);
        begin
            logic [2*W-1:0] held;
            held = product_o;
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                mbit_i = ~mbit_i;
                check(done_o == 1'b0, "R9 single done", {2*W-1'b0, done_o}, '0);
                check(product_o == held, "R6 product held", product_o, held);
            end
        end
    endtask

    initial begin
        logic [W-1:0] x, y;
        repeat (3) @(negedge clk);
        check(product_o == '0, "R1 reset product", product_o, '0);
        check(done_o == 1'b0, "R1 reset done", {2*W-1'b0, done_o}, '0);
        rst_n = 1'b1;
        run_mul(8'd0,   8'd0,   1'b0, -1);
        run_mul(8'd13,  8'd11,  1'b0, -1);
        run_mul(8'hFF,  8'hFF,  1'b0, -1);  // R4 max
        run_mul(8'h80,  8'h80,  1'b1, -1);  // R5 most negative squared
        run_mul(8'h80,  8'h7F,  1'b1, -1);  // R5
        run_mul(8'hFF,  8'hFF,  1'b1, -1);  // R5 -1*-1
        run_mul(8'h01,  8'hFF,  1'b1, -1);  // R5
        run_mul(8'h7F,  8'h80,  1'b1, -1);
        run_mul(8'hA5,  8'h3C,  1'b0, 3);   // R7 abandoned
        run_mul(8'h5A,  8'hC3,  1'b1, -1);  // R7 restart result
        x = 8'h1D; y = 8'h6B;
        for (int i = 0; i < 24; i++) begin
            x = x * 8'd37 + 8'd11;
            y = {y[6:0], y[7] ^ y[5] ^ y[4] ^ y[3]};
            run_mul(x, y, i[0], -1);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all dones seen", 16'(exp_q.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule